// File: doc/BRIEF.md
# Ready-bit polling SPI master

This block sits on the host side of an SPI link to a serial memory that has just been told to write. On a start pulse it repeatedly runs a status-read transaction and watches the ready bit of each returned byte. A byte fetched while the device may still be busy is never trusted beyond that one bit, so an all-ones reply simply means "busy". Once a poll shows the ready bit cleared, the block runs one further status-read transaction and hands that fresh byte to the host as the true status, together with a one-cycle done pulse.

Each transaction is a single chip-select-low frame of sixteen serial clocks. The first eight carry the status-read opcode on MOSI and the last eight shift the status byte in from MISO. The serial clock idles low (mode 0) and runs at a fixed division of the system clock. Chip select stays high for a minimum number of system clocks between frames. A poll limit stops the search with a one-cycle timeout pulse if the device never becomes ready.

Top module: `rdy_poll_master`

## Requirements
- R1: After reset, chip select is high, SCK is low, and neither done nor timeout is asserted.
- R2: Every transaction is one chip-select-low frame with exactly 16 SCK rising edges. During the first 8 rising edges MOSI carries the opcode 8'h05, most significant bit first, and SCK is low whenever chip select is high.
- R3: The status byte is taken from MISO on SCK rising edges 9 to 16, most significant bit first. The slave changes MISO on the falling edge before each of these rising edges.
- R4: In a polling frame only bit 0 (the ready bit, 1 = busy) is examined. A reply of 8'hFF, or any reply with bit 0 set, starts another polling frame whatever the other seven bits hold.
- R5: After a polling frame returns bit 0 = 0, exactly one more frame is run. Its whole byte appears on the status output while done pulses high for one cycle.
- R6: Between the end of one frame and the start of the next, chip select stays high for at least CS_GAP system clocks (4 in the bench configuration).
- R7: If MAX_POLLS polling frames in a row all report busy, no further frame is started, timeout pulses for one cycle, and done is not asserted for that run.
- R8: Each SCK high phase and each low phase inside a frame lasts CLK_DIV system clocks.
- R9: A start pulse that arrives while a polling run is in progress is ignored: it adds no frames and no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin polling (accepted only when idle) |
| done_o | output | 1 | One-cycle pulse: status_o holds the verified status byte |
| status_o | output | 8 | Status byte from the final confirming read |
| timeout_o | output | 1 | One-cycle pulse: the poll limit was reached without ready |
| spi_cs_n_o | output | 1 | Chip select, active low |
| spi_sck_o | output | 1 | Serial clock, idle low |
| spi_mosi_o | output | 1 | Serial data to the device |
| spi_miso_i | input | 1 | Serial data from the device |

## Verification
A wrong bit or edge count inside the frame shifter shows up within the same frame: the opcode seen on MOSI is wrong, or the number of SCK rising edges is not sixteen. A receive register that misaligns or keeps stale bits shows up at the next done pulse as a status byte that differs from what the slave sent. A poll counter or ready-bit decision that goes wrong changes the number of frames issued before done or timeout, so every scenario compares that count against what its scripted slave replies imply. A gap counter that is off by one is exposed at the next falling edge of chip select by measuring the preceding high time.

// File: rtl/rdy_poll_pkg.sv
package rdy_poll_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FRAME = 2'd1,
      ST_GAP   = 2'd2
   } poll_state_e;

   localparam int FRAME_BITS = 16;
   localparam int BYTE_BITS  = 8;
endpackage

// File: rtl/rdy_poll_clkdiv.sv
module rdy_poll_clkdiv #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic sck_o,
   output logic rise_o,
   output logic fall_o
);
   localparam int DIV_W = $clog2(CLK_DIV + 1);

   logic [DIV_W-1:0] cnt_q;
   logic             sck_q;
   logic             tick;

   assign tick   = en_i && (cnt_q == DIV_W'(CLK_DIV - 1));
   assign rise_o = tick && !sck_q;
   assign fall_o = tick && sck_q;
   assign sck_o  = sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sck_q <= 1'b0;
      end else if (!en_i) begin
         cnt_q <= '0;
         sck_q <= 1'b0;
      end else if (tick) begin
         cnt_q <= '0;
         sck_q <= ~sck_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R8: a rise strobe is followed by SCK high, a fall strobe by SCK low
   assert_rise_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> sck_q);
   assert_fall_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !sck_q);
endmodule

// File: rtl/rdy_poll_shifter.sv
module rdy_poll_shifter
   import rdy_poll_pkg::*;
#(
   parameter logic [7:0] OPCODE = 8'h05
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_i,
   input  logic                 rise_i,
   input  logic                 fall_i,
   input  logic                 miso_i,
   output logic                 mosi_o,
   output logic [BYTE_BITS-1:0] rx_o,
   output logic                 last_fall_o
);
   localparam int CNT_W = $clog2(FRAME_BITS);

   logic [BYTE_BITS-1:0] tx_q;
   logic [BYTE_BITS-1:0] rx_q;
   logic [CNT_W-1:0]     edge_q;

   assign mosi_o      = tx_q[BYTE_BITS-1];
   assign rx_o        = rx_q;
   assign last_fall_o = fall_i && (edge_q == CNT_W'(FRAME_BITS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q   <= '0;
         rx_q   <= '0;
         edge_q <= '0;
      end else if (load_i) begin
         tx_q   <= OPCODE;
         edge_q <= '0;
      end else begin
         if (rise_i) rx_q <= {rx_q[BYTE_BITS-2:0], miso_i};
         if (fall_i) begin
            tx_q   <= {tx_q[BYTE_BITS-2:0], 1'b0};
            edge_q <= edge_q + 1'b1;
         end
      end
   end

   // R2: a new frame is never loaded while SCK edges are being produced
   assert_no_load_midframe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> !(rise_i || fall_i));
endmodule

// File: rtl/rdy_poll_master.sv
module rdy_poll_master
   import rdy_poll_pkg::*;
#(
   parameter int         CLK_DIV      = 4,
   parameter int         CS_GAP       = 8,
   parameter int         MAX_POLLS    = 1000,
   parameter logic [7:0] RD_STATUS_OP = 8'h05,
   parameter int         READY_BIT    = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   output logic       done_o,
   output logic [7:0] status_o,
   output logic       timeout_o,
   output logic       spi_cs_n_o,
   output logic       spi_sck_o,
   output logic       spi_mosi_o,
   input  logic       spi_miso_i
);
   localparam int POLL_W = $clog2(MAX_POLLS + 1);
   localparam int GAP_W  = $clog2(CS_GAP + 1);

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (CS_GAP < 1) begin : g_bad_gap
         $error("CS_GAP must be at least 1");
      end
      if (MAX_POLLS < 1) begin : g_bad_polls
         $error("MAX_POLLS must be at least 1");
      end
      if (READY_BIT < 0 || READY_BIT >= BYTE_BITS) begin : g_bad_bit
         $error("READY_BIT must address a bit of the status byte");
      end
   endgenerate

   poll_state_e          state_q;
   logic                 final_q;
   logic [POLL_W-1:0]    poll_q;
   logic [GAP_W-1:0]     gap_q;
   logic                 done_q;
   logic                 tmo_q;
   logic [7:0]           status_q;

   logic                 sck_en, rise, fall, last_fall, load, gap_done;
   logic [BYTE_BITS-1:0] rx;
   logic                 ready_seen, poll_limit, next_frame;

   assign sck_en     = (state_q == ST_FRAME);
   assign gap_done   = (state_q == ST_GAP) && (gap_q == GAP_W'(CS_GAP - 1));
   assign ready_seen = !rx[READY_BIT];
   assign poll_limit = (poll_q == POLL_W'(MAX_POLLS - 1));
   assign next_frame = !final_q && (ready_seen || !poll_limit);
   assign load       = ((state_q == ST_IDLE) && start_i) || (gap_done && next_frame);

   rdy_poll_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (sck_en),
      .sck_o  (spi_sck_o),
      .rise_o (rise),
      .fall_o (fall)
   );

   rdy_poll_shifter #(.OPCODE(RD_STATUS_OP)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load),
      .rise_i      (rise),
      .fall_i      (fall),
      .miso_i      (spi_miso_i),
      .mosi_o      (spi_mosi_o),
      .rx_o        (rx),
      .last_fall_o (last_fall)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         final_q  <= 1'b0;
         poll_q   <= '0;
         gap_q    <= '0;
         done_q   <= 1'b0;
         tmo_q    <= 1'b0;
         status_q <= '0;
      end else begin
         done_q <= 1'b0;
         tmo_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_FRAME;
                  final_q <= 1'b0;
                  poll_q  <= '0;
               end
            end
            ST_FRAME: begin
               if (last_fall) begin
                  state_q <= ST_GAP;
                  gap_q   <= '0;
               end
            end
            ST_GAP: begin
               if (!gap_done) begin
                  gap_q <= gap_q + 1'b1;
               end else if (final_q) begin
                  done_q   <= 1'b1;
                  status_q <= rx;
                  final_q  <= 1'b0;
                  state_q  <= ST_IDLE;
               end else if (ready_seen) begin
                  final_q <= 1'b1;
                  state_q <= ST_FRAME;
               end else if (poll_limit) begin
                  tmo_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  poll_q  <= poll_q + 1'b1;
                  state_q <= ST_FRAME;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign spi_cs_n_o = (state_q != ST_FRAME);
   assign done_o     = done_q;
   assign timeout_o  = tmo_q;
   assign status_o   = status_q;

   // Checker state: cycles chip select has been high, saturating at CS_GAP
   logic [GAP_W-1:0] cs_hi_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cs_hi_q <= GAP_W'(CS_GAP);
      else if (!spi_cs_n_o)               cs_hi_q <= '0;
      else if (cs_hi_q < GAP_W'(CS_GAP))  cs_hi_q <= cs_hi_q + 1'b1;
   end

   // R6: chip select only falls after at least CS_GAP high cycles
   assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n_o) |-> (cs_hi_q == GAP_W'(CS_GAP)));
   // R2: the serial clock stays low while the device is deselected
   assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n_o |-> !spi_sck_o);
   // R7: done and timeout never coincide
   assert_done_tmo_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_q, tmo_q}));
   // R7: the poll counter never passes the limit
   assert_poll_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      poll_q < POLL_W'(MAX_POLLS));
   // R5: done only follows the close of a frame
   assert_done_after_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> spi_cs_n_o);
endmodule

// File: tb/rdy_poll_master_test.sv
`timescale 1ns/1ps
module rdy_poll_master_test;
   localparam int CLK_DIV   = 2;
   localparam int CS_GAP    = 4;
   localparam int MAX_POLLS = 5;
   localparam int TCLK      = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       done, timeout, spi_cs_n, spi_sck, spi_mosi;
   logic       spi_miso = 1'b1;
   logic [7:0] status;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   rdy_poll_master #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .MAX_POLLS(MAX_POLLS)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .done_o     (done),
      .status_o   (status),
      .timeout_o  (timeout),
      .spi_cs_n_o (spi_cs_n),
      .spi_sck_o  (spi_sck),
      .spi_mosi_o (spi_mosi),
      .spi_miso_i (spi_miso)
   );

   always #(TCLK/2) clk = ~clk;

   // ---------------- slave model and link monitors ----------------
   logic [7:0] resp [0:15];
   logic [7:0] op_sh;
   logic [7:0] cur;
   int  frames = 0, rises = 0, falls = 0;
   int  op_err = 0, len_err = 0, gap_err = 0, per_err = 0;
   bit  in_frame = 0, had_frame = 0;
   time last_edge = 0, last_cs_rise = 0;

   always @(negedge spi_cs_n) begin
      if (rst_n) begin
         if (had_frame && ($time - last_cs_rise) < CS_GAP * TCLK) gap_err++;
         in_frame = 1;
         rises = 0;
         falls = 0;
         op_sh = 8'h00;
         spi_miso = 1'b1;
         cur = (frames < 16) ? resp[frames] : 8'hFF;
         last_edge = $time;
      end
   end

   always @(posedge spi_sck) begin
      if (in_frame) begin
         if (rises > 0 && ($time - last_edge) != CLK_DIV * TCLK) per_err++;
         last_edge = $time;
         rises++;
         if (rises <= 8) op_sh = {op_sh[6:0], spi_mosi};
      end
   end

   always @(negedge spi_sck) begin
      if (in_frame) begin
         if (($time - last_edge) != CLK_DIV * TCLK) per_err++;
         last_edge = $time;
         falls++;
         if (falls >= 8 && falls <= 15) spi_miso = cur[15 - falls];
      end
   end

   always @(posedge spi_cs_n) begin
      if (in_frame) begin
         in_frame = 0;
         had_frame = 1;
         last_cs_rise = $time;
         if (op_sh != 8'h05) op_err++;
         if (rises != 16) len_err++;
         frames++;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d (0x%0h) expected=%0d (0x%0h)",
                  req, what, act, act, exp, exp);
      end
   endtask

   task automatic clear_link(input logic [7:0] fill);
      for (int i = 0; i < 16; i++) resp[i] = fill;
      frames = 0;
      op_err = 0;
      len_err = 0;
      gap_err = 0;
      per_err = 0;
   endtask

   task automatic pulse_start;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_end(output bit got_done, output bit got_tmo,
                           output logic [7:0] st, output int dones);
      got_done = 0;
      got_tmo = 0;
      st = 8'h00;
      dones = 0;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (done) begin
            dones++;
            got_done = 1;
            st = status;
         end
         if (timeout) got_tmo = 1;
         if (got_done || got_tmo) break;
      end
   endtask

   task automatic check_link(input string tag);
      chk(op_err == 0, "R2", {tag, " opcode on MOSI"}, op_err, 0);
      chk(len_err == 0, "R2", {tag, " sixteen SCK rises per frame"}, len_err, 0);
      chk(gap_err == 0, "R6", {tag, " CS high gap"}, gap_err, 0);
      chk(per_err == 0, "R8", {tag, " SCK phase length"}, per_err, 0);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      @(negedge clk);
      chk(spi_cs_n == 1'b1, "R1", "cs_n after reset", int'(spi_cs_n), 1);
      chk(spi_sck == 1'b0, "R1", "sck after reset", int'(spi_sck), 0);
      chk(done == 1'b0 && timeout == 1'b0, "R1", "done/timeout after reset",
          int'({done, timeout}), 0);
   endtask

   task automatic t_ready_first;
      bit gd, gt; logic [7:0] st; int nd;
      clear_link(8'hFF);
      resp[0] = 8'hC2;
      resp[1] = 8'hA5;
      pulse_start();
      wait_end(gd, gt, st, nd);
      chk(gd && !gt, "R5", "ready first: done seen", int'({gd, gt}), 2);
      chk(st == 8'hA5, "R3", "ready first: status byte", int'(st), 8'hA5);
      chk(frames == 2, "R5", "ready first: frame count", frames, 2);
      check_link("ready first");
   endtask

   task automatic t_busy_ff;
      bit gd, gt; logic [7:0] st; int nd;
      clear_link(8'hFF);
      resp[3] = 8'h7E;
      resp[4] = 8'h3C;
      pulse_start();
      wait_end(gd, gt, st, nd);
      chk(gd && !gt, "R4", "all-ones busy: done seen", int'({gd, gt}), 2);
      chk(frames == 5, "R4", "all-ones busy: frame count", frames, 5);
      chk(st == 8'h3C, "R5", "all-ones busy: final status", int'(st), 8'h3C);
      check_link("all-ones busy");
   endtask

   task automatic t_bit0_only;
      bit gd, gt; logic [7:0] st; int nd;
      clear_link(8'hFF);
      resp[0] = 8'h01;
      resp[1] = 8'hFD;
      resp[2] = 8'hFE;
      resp[3] = 8'h81;
      pulse_start();
      wait_end(gd, gt, st, nd);
      chk(frames == 4, "R4", "bit0 only: frame count", frames, 4);
      chk(st == 8'h81, "R5", "bit0 only: final byte reported whole", int'(st), 8'h81);
      check_link("bit0 only");
   endtask

   task automatic t_timeout;
      bit gd, gt; logic [7:0] st; int nd;
      clear_link(8'hFF);
      pulse_start();
      wait_end(gd, gt, st, nd);
      chk(gt && !gd, "R7", "timeout pulse without done", int'({gd, gt}), 1);
      chk(frames == MAX_POLLS, "R7", "frames before timeout", frames, MAX_POLLS);
      @(negedge clk);
      chk(timeout == 1'b0, "R7", "timeout is one cycle", int'(timeout), 0);
      repeat (300) @(negedge clk);
      chk(frames == MAX_POLLS, "R7", "no frame after timeout", frames, MAX_POLLS);
      chk(spi_cs_n == 1'b1, "R7", "cs_n high after timeout", int'(spi_cs_n), 1);
      check_link("timeout");
   endtask

   task automatic t_start_ignored;
      bit gd, gt; logic [7:0] st; int nd;
      clear_link(8'hFF);
      resp[1] = 8'h00;
      resp[2] = 8'h66;
      pulse_start();
      repeat (40) @(negedge clk);
      pulse_start();
      wait_end(gd, gt, st, nd);
      chk(st == 8'h66 && gd, "R9", "status with extra start", int'(st), 8'h66);
      repeat (300) @(negedge clk);
      chk(frames == 3, "R9", "extra start added no frames", frames, 3);
      check_link("start ignored");
   endtask

   // ---------------- watchdog ----------------
   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   // ---------------- main ----------------
   initial begin
      for (int i = 0; i < 16; i++) resp[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ready_first();
      t_busy_ff();
      t_bit0_only();
      t_timeout();
      t_start_ignored();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule